// File: doc/BRIEF.md
# Wait-Request Allowance Command Adapter

This block joins a memory-mapped master and a memory-mapped slave that disagree on how many commands may still cross the link once waitrequest goes high. The master is allowed M_ALLOW late commands and the slave only S_ALLOW. Read and write commands, each with address, write data and byte enables, go from the master side to the slave side. When the master's allowance is the larger one, every command enters a small in-order buffer. The buffer soaks up the commands that the slave could not take.

Waitrequest toward the master depends only on how full the buffer is. It rises while room remains for a whole master allowance, so the buffer cannot overflow. A counter on the slave side limits how many commands are presented while the slave's waitrequest is high. When the slave's allowance is zero, a presented command is instead held steady until the slave drops waitrequest.

If M_ALLOW is less than or equal to S_ALLOW, the buffer is left out and the block becomes wires. Read data and write responses do not go through this block.

Top module: `wra_adapter`

## Requirements
- R1: After reset the buffer is empty: no command is presented to the slave, and m_waitreq is low.
- R2: Every command reaches the slave with its address, write data and byte enables unchanged. Its kind is kept: a master write appears on s_write and a master read appears on s_read.
- R3: In buffered mode the buffer holds DEPTH = M_ALLOW + SLACK entries, and m_waitreq is high exactly when the free entries number M_ALLOW or fewer.
- R4: A master that keeps within its allowance never pushes a command into a full buffer.
- R5: With S_ALLOW > 0, at most S_ALLOW commands are presented to the slave during one stretch of s_waitreq high. The count starts again from zero whenever s_waitreq is low.
- R6: With S_ALLOW = 0, a presented command stays presented and unchanged while s_waitreq is high, and it leaves the buffer only in a cycle with s_waitreq low.
- R7: Commands leave the buffer in arrival order, so older buffered commands always go ahead of newer ones. A command is presented to the slave no earlier than the cycle after the master issued it.
- R8: When M_ALLOW <= S_ALLOW, the slave outputs equal the master inputs in the same cycle, and m_waitreq equals s_waitreq.
- R9: In buffered mode a command is presented in every cycle in which the buffer is not empty and the slave's allowance permits it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_read | input | 1 | Master read command |
| m_write | input | 1 | Master write command |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_byteen | input | DATA_W/8 | Master byte enables |
| m_waitreq | output | 1 | Stall request toward the master |
| s_read | output | 1 | Read command to the slave |
| s_write | output | 1 | Write command to the slave |
| s_addr | output | ADDR_W | Address to the slave |
| s_wdata | output | DATA_W | Write data to the slave |
| s_byteen | output | DATA_W/8 | Byte enables to the slave |
| s_waitreq | input | 1 | Stall request from the slave |

## Verification
The assertions assume that the master never issues more than M_ALLOW commands during one stretch of m_waitreq high. They also assume that m_read and m_write are never high together. The stimulus keeps both rules: the bench master counts its own late commands against the waitrequest it sees, and it draws one command kind per cycle. The slave side is free; s_waitreq runs through long stalls, random toggling, idle stretches and sparse stalls. This drives the buffer to full and to empty under each slave allowance.

// File: rtl/wra_pkg.sv
package wra_pkg;

    typedef enum logic {
        CMD_RD = 1'b0,
        CMD_WR = 1'b1
    } cmd_kind_e;

    // Buffering is only needed when the master may overrun the slave.
    function automatic bit need_buffer(input int m_allow, input int s_allow);
        return m_allow > s_allow;
    endfunction

    // Entries: one full master allowance plus slack for throughput.
    function automatic int buf_depth(input int m_allow, input int slack);
        return m_allow + slack;
    endfunction

    function automatic int occ_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/wra_cmd_fifo.sv
module wra_cmd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [OCC_W-1:0] occ
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign head = slots[rd_ptr];

endmodule

// File: rtl/wra_issue_ctl.sv
module wra_issue_ctl #(
    parameter int S_ALLOW = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic s_waitreq,
    input  logic have_cmd,
    output logic present,
    output logic pop
);
    generate
        if (S_ALLOW == 0) begin : g_hold
            // Present and hold; the command leaves only when the slave is ready.
            assign present = have_cmd;
            assign pop     = have_cmd && !s_waitreq;
        end else begin : g_allow
            localparam int CW = $clog2(S_ALLOW + 2);
            logic [CW-1:0] late_cnt;

            assign present = have_cmd && (!s_waitreq || late_cnt < CW'(S_ALLOW));
            assign pop     = present;

            always_ff @(posedge clk) begin
                if (rst || !s_waitreq) begin
                    late_cnt <= '0;
                end else if (present) begin
                    late_cnt <= late_cnt + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wra_adapter.sv
module wra_adapter
    import wra_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int M_ALLOW = 4,
    parameter int S_ALLOW = 1,
    parameter int SLACK   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                m_read,
    input  logic                m_write,
    input  logic [ADDR_W-1:0]   m_addr,
    input  logic [DATA_W-1:0]   m_wdata,
    input  logic [DATA_W/8-1:0] m_byteen,
    output logic                m_waitreq,
    output logic                s_read,
    output logic                s_write,
    output logic [ADDR_W-1:0]   s_addr,
    output logic [DATA_W-1:0]   s_wdata,
    output logic [DATA_W/8-1:0] s_byteen,
    input  logic                s_waitreq
);
    localparam int  BE_W     = DATA_W / 8;
    localparam bit  BUFFERED = need_buffer(M_ALLOW, S_ALLOW);
    localparam int  DEPTH    = buf_depth(M_ALLOW, SLACK);
    localparam int  OCC_W    = occ_width(DEPTH);

    logic [OCC_W-1:0] occ;

    generate
        if (BUFFERED) begin : g_buf
            typedef struct packed {
                cmd_kind_e         kind;
                logic [ADDR_W-1:0] addr;
                logic [DATA_W-1:0] data;
                logic [BE_W-1:0]   be;
            } cmd_t;
            localparam int EW = $bits(cmd_t);

            cmd_t          in_cmd;
            cmd_t          head;
            logic [EW-1:0] head_bits;
            logic          push;
            logic          have_cmd;
            logic          present;
            logic          pop;

            assign in_cmd = '{kind: (m_write ? CMD_WR : CMD_RD),
                              addr: m_addr, data: m_wdata, be: m_byteen};
            assign push   = m_read || m_write;

            wra_cmd_fifo #(
                .WIDTH (EW),
                .DEPTH (DEPTH),
                .OCC_W (OCC_W)
            ) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .push      (push),
                .push_data (in_cmd),
                .pop       (pop),
                .head      (head_bits),
                .occ       (occ)
            );

            assign head     = cmd_t'(head_bits);
            assign have_cmd = (occ != '0);

            wra_issue_ctl #(
                .S_ALLOW (S_ALLOW)
            ) u_issue (
                .clk       (clk),
                .rst       (rst),
                .s_waitreq (s_waitreq),
                .have_cmd  (have_cmd),
                .present   (present),
                .pop       (pop)
            );

            assign s_read    = present && (head.kind == CMD_RD);
            assign s_write   = present && (head.kind == CMD_WR);
            assign s_addr    = head.addr;
            assign s_wdata   = head.data;
            assign s_byteen  = head.be;
            // Stall while a whole master allowance could no longer fit.
            assign m_waitreq = (DEPTH - int'(occ)) <= M_ALLOW;
        end else begin : g_pass
            assign occ       = '0;
            assign s_read    = m_read;
            assign s_write   = m_write;
            assign s_addr    = m_addr;
            assign s_wdata   = m_wdata;
            assign s_byteen  = m_byteen;
            assign m_waitreq = s_waitreq;
        end
    endgenerate

endmodule

// File: rtl/wra_adapter_chk.sv
module wra_adapter_chk
    import wra_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int M_ALLOW = 4,
    parameter int S_ALLOW = 1,
    parameter int SLACK   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                m_read,
    input logic                m_write,
    input logic                m_waitreq,
    input logic                s_read,
    input logic                s_write,
    input logic [ADDR_W-1:0]   s_addr,
    input logic [DATA_W-1:0]   s_wdata,
    input logic [DATA_W/8-1:0] s_byteen,
    input logic                s_waitreq,
    input logic [occ_width(buf_depth(M_ALLOW, SLACK))-1:0] occ
);
    localparam bit BUFFERED = need_buffer(M_ALLOW, S_ALLOW);
    localparam int DEPTH    = buf_depth(M_ALLOW, SLACK);

    logic [15:0] s_late;
    logic [15:0] m_late;
    logic        s_cmd;
    logic        m_cmd;

    assign s_cmd = s_read || s_write;
    assign m_cmd = m_read || m_write;

    always_ff @(posedge clk) begin
        if (rst || !s_waitreq) s_late <= '0;
        else if (s_cmd && s_late != 16'hFFFF) s_late <= s_late + 1'b1;
        if (rst || !m_waitreq) m_late <= '0;
        else if (m_cmd && m_late != 16'hFFFF) m_late <= m_late + 1'b1;
    end

    AST_MASTER_WITHIN_ALLOW: assert property (@(posedge clk) disable iff (rst)
        (m_waitreq && m_cmd) |-> (m_late < 16'(M_ALLOW))); // R3

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (rst)
        (BUFFERED && int'(occ) == DEPTH) |-> m_waitreq); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (BUFFERED && m_cmd) |-> (int'(occ) < DEPTH)); // R4

    AST_SLAVE_ALLOW: assert property (@(posedge clk) disable iff (rst)
        (S_ALLOW > 0 && s_waitreq && s_cmd) |-> (s_late < 16'(S_ALLOW))); // R5

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (BUFFERED && S_ALLOW == 0 && s_waitreq && s_cmd) |=>
        (s_cmd && $stable(s_write) && $stable(s_addr) && $stable(s_wdata) && $stable(s_byteen))); // R6

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (BUFFERED && occ == '0) |-> !s_cmd); // R7

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(s_read && s_write)); // R2

endmodule

bind wra_adapter wra_adapter_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .M_ALLOW (M_ALLOW),
    .S_ALLOW (S_ALLOW),
    .SLACK   (SLACK)
) u_chk (.*);

// File: tb/wra_adapter_bench.sv
`timescale 1ns/1ps

module wra_harness #(
    parameter int MA    = 4,
    parameter int SA    = 1,
    parameter int SLACK = 2
) (
    input  logic clk,
    input  logic rst,
    output int   n_chk,
    output int   n_bad,
    output logic done
);
    localparam bit PASS  = (MA <= SA);
    localparam int DEPTH = MA + SLACK;

    logic        m_read, m_write, m_waitreq;
    logic [15:0] m_addr;
    logic [31:0] m_wdata;
    logic [3:0]  m_byteen;
    logic        s_read, s_write, s_waitreq;
    logic [15:0] s_addr;
    logic [31:0] s_wdata;
    logic [3:0]  s_byteen;

    wra_adapter #(
        .ADDR_W (16), .DATA_W (32), .M_ALLOW (MA), .S_ALLOW (SA), .SLACK (SLACK)
    ) u_wra_adapter (
        .clk (clk), .rst (rst),
        .m_read (m_read), .m_write (m_write), .m_addr (m_addr),
        .m_wdata (m_wdata), .m_byteen (m_byteen), .m_waitreq (m_waitreq),
        .s_read (s_read), .s_write (s_write), .s_addr (s_addr),
        .s_wdata (s_wdata), .s_byteen (s_byteen), .s_waitreq (s_waitreq)
    );

    // Entry layout: {is_write, addr[15:0], data[31:0], be[3:0]}
    typedef logic [52:0] ent_t;
    ent_t pending[$];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (MA=%0d SA=%0d): actual %0h expected %0h",
                     req, what, MA, SA, act, exp);
        end
    endtask

    initial begin
        int   m_late;
        int   s_late;
        n_chk = 0; n_bad = 0; done = 0;
        m_late = 0; s_late = 0;
        m_read = 0; m_write = 0; m_addr = '0; m_wdata = '0; m_byteen = '0;
        s_waitreq = 0;
        @(negedge clk);
        while (rst) @(negedge clk);
        #1;
        chk("R1", "m_waitreq after reset", 64'(m_waitreq), 64'(0));
        chk("R1", "slave command after reset", 64'({s_read, s_write}), 64'(0));
        for (int c = 0; c < 1000; c++) begin
            logic  sw, go, exp_mw, exp_pres;
            int    rate;
            ent_t  mc, exp_head;
            string req;
            @(negedge clk);
            if (c < 40)       sw = 1'b1;
            else if (c < 400) sw = 1'($urandom_range(1, 0));
            else if (c < 600) sw = 1'b0;
            else              sw = ($urandom_range(3, 0) == 0);
            rate = (c >= 400 && c < 600) ? 100 : 70;
            s_waitreq = sw;
            #1;
            exp_mw = PASS ? sw : ((DEPTH - pending.size()) <= MA);
            req = PASS ? "R8" : ((pending.size() == DEPTH) ? "R4" : "R3");
            chk(req, "m_waitreq", 64'(m_waitreq), 64'(exp_mw));

            go = ($urandom_range(99, 0) < rate) && (!m_waitreq || m_late < MA);
            mc = {1'($urandom_range(1, 0)), 16'($urandom), 32'($urandom), 4'($urandom)};
            m_read   = go && !mc[52];
            m_write  = go && mc[52];
            m_addr   = mc[51:36];
            m_wdata  = mc[35:4];
            m_byteen = mc[3:0];
            #1;

            if (PASS) begin
                exp_pres = go;
                exp_head = mc;
                req = "R8";
            end else begin
                exp_pres = (pending.size() > 0) && (SA == 0 || !sw || s_late < SA);
                exp_head = (pending.size() > 0) ? pending[0] : '0;
                if (pending.size() == 0) req = "R7";
                else if (sw && SA == 0)  req = "R6";
                else if (sw)             req = "R5";
                else                     req = "R9";
            end
            chk(req, "slave command presented", 64'(s_read | s_write), 64'(exp_pres));
            if (exp_pres) begin
                chk(PASS ? "R8" : "R2", "slave command fields",
                    64'({s_read, s_write, s_addr, s_wdata, s_byteen}),
                    64'({~exp_head[52], exp_head}));
            end

            if (!PASS) begin
                if (exp_pres && (!sw || SA > 0)) void'(pending.pop_front());
                if (go) pending.push_back(mc);
            end
            s_late = !sw ? 0 : s_late + ((exp_pres && SA > 0) ? 1 : 0);
            m_late = !m_waitreq ? 0 : m_late + (go ? 1 : 0);
        end
        @(negedge clk);
        m_read = 0; m_write = 0;
        done = 1;
    end

endmodule

module wra_adapter_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic timed_out = 1'b0;

    always #4 clk = ~clk;

    int   c0, b0, c1, b1, c2, b2;
    logic d0, d1, d2;

    wra_harness #(.MA(4), .SA(1), .SLACK(2)) u_h_buf  (.clk(clk), .rst(rst), .n_chk(c0), .n_bad(b0), .done(d0));
    wra_harness #(.MA(3), .SA(0), .SLACK(2)) u_h_hold (.clk(clk), .rst(rst), .n_chk(c1), .n_bad(b1), .done(d1));
    wra_harness #(.MA(1), .SA(2), .SLACK(2)) u_h_pass (.clk(clk), .rst(rst), .n_chk(c2), .n_bad(b2), .done(d2));

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    end

    initial begin
        repeat (50000) @(posedge clk);
        timed_out = 1'b1;
    end

    initial begin
        int total;
        int bad;
        wait ((d0 && d1 && d2) || timed_out);
        total = c0 + c1 + c2;
        bad   = b0 + b1 + b2;
        if (timed_out && !(d0 && d1 && d2)) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end

endmodule